// File: doc/BRIEF.md
# Triple-Redundant Bus Voter with Core Resynchronization

This block sits between three identical processor cores that run in lockstep and a single memory port. Each core presents its own request, write-enable, address and write-data lines. The block sends the bitwise two-of-three majority of these lines to memory. A single misbehaving core therefore never reaches memory. On any bus cycle where one copy disagrees with the voted value, the block raises an error flag. It also records the disagreeing core in a sticky mask.

A disagreement starts a recovery sequence. First, the block asks all cores to dump their context (registers, program counter, status word) through the voter, so that memory receives the voted context. Next, it holds every core in reset for a programmable number of cycles. Finally, it asks the cores to reload that context and returns to normal running. A busy output marks the whole period in which the system is unavailable.

If a second, different core disagrees while the context is being dumped, the voted context can no longer be trusted. In that case the block stops in a fatal state until its own reset.

Top module: `tmr_bus_voter`

## Requirements
- R1: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` are the bitwise majority of the three core copies. Core i occupies bit i of `cores_req`/`cores_we` and slice [i*W +: W] of `cores_addr`/`cores_wdata`.
- R2: A bus cycle is valid when the voted request is 1. On a valid cycle in normal running or context dump, `err_flag` is 1 in the same cycle exactly when some copy of request, write-enable, address or data differs from the voted value. On cycles where the voted request is 0, `err_flag` is 0.
- R3: `err_core` bit i is set when core i causes the error that starts recovery. The mask holds through the dump, reset and reload phases and is cleared when normal running resumes.
- R4: In the cycle after `err_flag` rises during normal running, `save_req` and `busy` are 1.
- R5: `save_req` stays 1 until the majority of `cores_save_done` is 1. From the next cycle, `save_req` is 0 and `core_rst_n` is 0 for max(`rst_len`,1) cycles.
- R6: While `core_rst_n` is 0, `mem_req` is 0.
- R7: After the reset window, `restore_req` is 1 until the majority of `cores_restore_done` is 1. In the next cycle, `busy`, `restore_req` and `err_core` are all 0.
- R8: During the dump, an error from a core not already in `err_core` sets `fatal` in the next cycle. `fatal` then stays 1 until block reset, with `busy` 1 and `mem_req`, `save_req` and `core_rst_n`... held as follows: `mem_req` 0, `save_req` 0, `core_rst_n` 1. Done handshakes are ignored.
- R9: During the dump, further errors from the core already in `err_core` do not set `fatal`.
- R10: After block reset: `busy`, `fatal`, `save_req` and `restore_req` are 0, `err_core` is 0 and `core_rst_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cores_req | input | 3 | Per-core bus request |
| cores_we | input | 3 | Per-core write enable |
| cores_addr | input | 3*AW | Per-core address, core i at [i*AW +: AW] |
| cores_wdata | input | 3*DW | Per-core write data, core i at [i*DW +: DW] |
| cores_save_done | input | 3 | Per-core context dump finished |
| cores_restore_done | input | 3 | Per-core context reload finished |
| rst_len | input | CNT_W | Core reset window length in cycles (0 treated as 1) |
| mem_req | output | 1 | Voted request to memory |
| mem_we | output | 1 | Voted write enable |
| mem_addr | output | AW | Voted address |
| mem_wdata | output | DW | Voted write data |
| err_flag | output | 1 | Disagreement on a valid bus cycle |
| err_core | output | 3 | Sticky mask of the core that triggered recovery |
| save_req | output | 1 | Request to cores to dump context |
| core_rst_n | output | 1 | Active-low reset to all cores |
| restore_req | output | 1 | Request to cores to reload context |
| busy | output | 1 | Recovery in progress or halted |
| fatal | output | 1 | Unrecoverable second-core error |

## Verification
The assertions assume that `rst_len` stays constant from the start of a recovery until its reset window ends. They also assume that the cores raise their done handshakes only while the matching request is high. The bench changes `rst_len` only between runs, separated by a block reset. It drives each done vector only during the phase that awaits it, except in the fatal case, where ignoring a late handshake is itself the point under test. Bus stimulus changes one core at a time, so at most one copy disagrees, except in the deliberate second-core fault.

// File: rtl/tmr_voter_pkg.sv
package tmr_voter_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SAVE    = 3'd1,
    ST_RESET   = 3'd2,
    ST_RESTORE = 3'd3,
    ST_HALT    = 3'd4
  } rec_state_e;

  localparam int unsigned NCOPY = 3;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/tmr_majority.sv
module tmr_majority #(
  parameter int unsigned W = 8
) (
  input  logic [3*W-1:0] copies,
  output logic [W-1:0]   voted,
  output logic [2:0]     differs
);
  logic [W-1:0] cp [3];

  for (genvar i = 0; i < 3; i++) begin : g_unpack
    assign cp[i] = copies[i*W +: W];
  end

  assign voted = (cp[0] & cp[1]) | (cp[0] & cp[2]) | (cp[1] & cp[2]);

  for (genvar i = 0; i < 3; i++) begin : g_cmp
    assign differs[i] = |(cp[i] ^ voted);
  end
endmodule

// File: rtl/tmr_recovery_fsm.sv
module tmr_recovery_fsm
  import tmr_voter_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mis_vec,
  input  logic             bus_valid,
  input  logic             save_done,
  input  logic             restore_done,
  input  logic [CNT_W-1:0] rst_len,
  output logic             err_flag,
  output logic [2:0]       err_core,
  output logic             save_req,
  output logic             core_rst_n,
  output logic             restore_req,
  output logic             busy,
  output logic             fatal
);
  rec_state_e       state_q, state_d;
  logic [2:0]       mask_q, mask_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] last_cnt;
  logic             watching;
  logic             new_core_err;

  assign last_cnt     = (rst_len == '0) ? '0 : rst_len - 1'b1;
  assign watching     = (state_q == ST_RUN) || (state_q == ST_SAVE);
  assign err_flag     = watching && bus_valid && (|mis_vec);
  assign new_core_err = err_flag && (|(mis_vec & ~mask_q));

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (err_flag) begin
          state_d = ST_SAVE;
          mask_d  = mis_vec;
        end
      end
      ST_SAVE: begin
        if (new_core_err) begin
          state_d = ST_HALT;
        end else if (save_done) begin
          state_d = ST_RESET;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_RESET: begin
        if (cnt_q >= last_cnt) begin
          state_d = ST_RESTORE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_RESTORE: begin
        if (restore_done) begin
          state_d = ST_RUN;
          mask_d  = '0;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      mask_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign err_core    = mask_q;
  assign save_req    = (state_q == ST_SAVE);
  assign core_rst_n  = (state_q != ST_RESET);
  assign restore_req = (state_q == ST_RESTORE);
  assign busy        = (state_q != ST_RUN);
  assign fatal       = (state_q == ST_HALT);

  p_enter_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && err_flag) |=> (save_req && busy));

  p_save_to_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && save_done && !(err_flag && |(mis_vec & ~err_core))) |=> (!core_rst_n && !save_req));

  p_reload_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(core_rst_n) && core_rst_n) |-> restore_req);

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> (fatal && busy && core_rst_n && !save_req));

  p_mask_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !restore_req) |=> (err_core == $past(err_core)));
endmodule

// File: rtl/tmr_bus_voter.sv
module tmr_bus_voter
  import tmr_voter_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cores_req,
  input  logic [2:0]        cores_we,
  input  logic [3*AW-1:0]   cores_addr,
  input  logic [3*DW-1:0]   cores_wdata,
  input  logic [2:0]        cores_save_done,
  input  logic [2:0]        cores_restore_done,
  input  logic [CNT_W-1:0]  rst_len,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              err_flag,
  output logic [2:0]        err_core,
  output logic              save_req,
  output logic              core_rst_n,
  output logic              restore_req,
  output logic              busy,
  output logic              fatal
);
  localparam int unsigned BW = 2 + AW + DW;

  logic [3*BW-1:0] bus_copies;
  logic [BW-1:0]   bus_voted;
  logic [2:0]      mis_vec;
  logic            req_voted;

  for (genvar i = 0; i < NCOPY; i++) begin : g_pack
    assign bus_copies[i*BW +: BW] = {cores_req[i], cores_we[i],
                                     cores_addr[i*AW +: AW], cores_wdata[i*DW +: DW]};
  end

  tmr_majority #(.W(BW)) u_vote (
    .copies  (bus_copies),
    .voted   (bus_voted),
    .differs (mis_vec)
  );

  assign req_voted = bus_voted[BW-1];
  assign mem_we    = bus_voted[BW-2];
  assign mem_addr  = bus_voted[DW +: AW];
  assign mem_wdata = bus_voted[DW-1:0];
  assign mem_req   = req_voted && core_rst_n && !fatal;

  tmr_recovery_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .mis_vec      (mis_vec),
    .bus_valid    (req_voted),
    .save_done    (maj3(cores_save_done)),
    .restore_done (maj3(cores_restore_done)),
    .rst_len      (rst_len),
    .err_flag     (err_flag),
    .err_core     (err_core),
    .save_req     (save_req),
    .core_rst_n   (core_rst_n),
    .restore_req  (restore_req),
    .busy         (busy),
    .fatal        (fatal)
  );

  p_addr_majority_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cores_addr[0 +: AW] == cores_addr[AW +: AW]) |-> (mem_addr == cores_addr[0 +: AW]));

  p_data_majority_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cores_wdata[DW +: DW] == cores_wdata[2*DW +: DW]) |-> (mem_wdata == cores_wdata[DW +: DW]));

  p_quiet_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> !mem_req);

  p_agree_no_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_copies[0 +: BW] == bus_copies[BW +: BW]) && (bus_copies[BW +: BW] == bus_copies[2*BW +: BW])) |-> !err_flag);
endmodule

// File: tb/tmr_bus_voter_bench.sv
`timescale 1ns/100ps
module tmr_bus_voter_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cores_req, cores_we, cores_save_done, cores_restore_done;
  logic [3*AW-1:0] cores_addr;
  logic [3*DW-1:0] cores_wdata;
  logic [CW-1:0] rst_len;
  logic mem_req, mem_we, err_flag, save_req, core_rst_n, restore_req, busy, fatal;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [2:0] err_core;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tmr_bus_voter #(.AW(AW), .DW(DW), .CNT_W(CW)) u_tmr_bus_voter (
    .clk(clk), .rst_n(rst_n), .cores_req(cores_req), .cores_we(cores_we),
    .cores_addr(cores_addr), .cores_wdata(cores_wdata),
    .cores_save_done(cores_save_done), .cores_restore_done(cores_restore_done),
    .rst_len(rst_len), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .err_flag(err_flag), .err_core(err_core),
    .save_req(save_req), .core_rst_n(core_rst_n), .restore_req(restore_req),
    .busy(busy), .fatal(fatal)
  );

  typedef struct packed {
    logic [15:0] a0, a1, a2, d0, d1, d2;
    logic [2:0]  we;
    logic [15:0] ea, ed;
    logic        ewe, eerr;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'h1234, 16'h1234, 16'h1234, 16'h5555, 16'h5555, 16'h5555, 3'b111, 16'h1234, 16'h5555, 1'b1, 1'b0},
    '{16'h1234, 16'hFFFF, 16'h1234, 16'h5555, 16'h5555, 16'h5555, 3'b111, 16'h1234, 16'h5555, 1'b1, 1'b1},
    '{16'h00FF, 16'h0F0F, 16'h3333, 16'h5555, 16'h5555, 16'h5555, 3'b000, 16'h033F, 16'h5555, 1'b0, 1'b1},
    '{16'h0010, 16'h0010, 16'h0010, 16'hABCD, 16'hABCD, 16'h0000, 3'b111, 16'h0010, 16'hABCD, 1'b1, 1'b1},
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 3'b000, 16'h0000, 16'h0000, 1'b0, 1'b0},
    '{16'h0042, 16'h0042, 16'h0042, 16'h7777, 16'h7777, 16'h7777, 3'b011, 16'h0042, 16'h7777, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic idle_inputs();
    cores_req = 3'b000; cores_we = 3'b000; cores_addr = '0; cores_wdata = '0;
    cores_save_done = 3'b000; cores_restore_done = 3'b000;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic drive_equal(input logic [15:0] a, input logic [15:0] d);
    cores_req = 3'b111; cores_we = 3'b111;
    cores_addr = {a, a, a}; cores_wdata = {d, d, d};
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n_low;
    rst_len = 8'd3;
    do_reset();
    #0.5;
    chk("R10 busy", busy, 0); chk("R10 fatal", fatal, 0);
    chk("R10 err_core", err_core, 0); chk("R10 save_req", save_req, 0);
    chk("R10 restore_req", restore_req, 0); chk("R10 core_rst_n", core_rst_n, 1);

    for (int i = 0; i < 6; i++) begin
      do_reset();
      cores_req = 3'b111; cores_we = VEC[i].we;
      cores_addr = {VEC[i].a2, VEC[i].a1, VEC[i].a0};
      cores_wdata = {VEC[i].d2, VEC[i].d1, VEC[i].d0};
      #0.5;
      chk("R1 addr", mem_addr, VEC[i].ea);
      chk("R1 data", mem_wdata, VEC[i].ed);
      chk("R1 we", mem_we, VEC[i].ewe);
      chk("R2 err_flag", err_flag, VEC[i].eerr);
    end

    // R2: disagreement on an invalid cycle is not flagged
    do_reset();
    cores_req = 3'b001; cores_addr = {16'h1, 16'h2, 16'h3};
    #0.5;
    chk("R2 no flag when idle", err_flag, 0);
    chk("R2 mem_req idle", mem_req, 0);
    step();
    chk("R2 stays running", busy, 0);

    // Full recovery with core 2 faulty, reset window 3
    do_reset();
    drive_equal(16'h0100, 16'h2222);
    cores_wdata[2*DW +: DW] = 16'h2A22;
    #0.5;
    chk("R2 flag core2", err_flag, 1);
    chk("R1 masked data", mem_wdata, 16'h2222);
    step();
    chk("R4 save_req", save_req, 1); chk("R4 busy", busy, 1);
    chk("R3 err_core", err_core, 3'b100);
    step();
    chk("R9 same core no fatal", fatal, 0);
    chk("R5 save_req held", save_req, 1);
    drive_equal(16'h0100, 16'h2222);
    cores_save_done = 3'b011;
    step();
    cores_save_done = 3'b000;
    chk("R5 save_req low", save_req, 0);
    chk("R6 mem_req in reset", mem_req, 0);
    n_low = 0;
    while (!core_rst_n && n_low < 20) begin n_low++; step(); end
    chk("R5 reset window 3", n_low, 3);
    chk("R7 restore_req", restore_req, 1);
    chk("R3 err_core kept", err_core, 3'b100);
    step();
    chk("R7 waits for done", restore_req, 1);
    cores_restore_done = 3'b110;
    step();
    cores_restore_done = 3'b000;
    chk("R7 busy cleared", busy, 0);
    chk("R7 restore_req cleared", restore_req, 0);
    chk("R3 err_core cleared", err_core, 0);
    chk("R7 mem_req back", mem_req, 1);

    // Reset window with rst_len 0 lasts one cycle
    rst_len = 8'd0;
    do_reset();
    drive_equal(16'h0004, 16'h0001);
    cores_we = 3'b110;
    step();
    drive_equal(16'h0004, 16'h0001);
    cores_save_done = 3'b111;
    step();
    cores_save_done = 3'b000;
    n_low = 0;
    while (!core_rst_n && n_low < 20) begin n_low++; step(); end
    chk("R5 reset window min 1", n_low, 1);

    // Second core fails during the dump
    rst_len = 8'd2;
    do_reset();
    drive_equal(16'h0800, 16'h0000);
    cores_addr[0 +: AW] = 16'h0801;
    step();
    chk("R3 err_core core0", err_core, 3'b001);
    drive_equal(16'h0800, 16'h0000);
    cores_addr[AW +: AW] = 16'h0C00;
    step();
    chk("R8 fatal", fatal, 1);
    chk("R8 save_req low", save_req, 0);
    drive_equal(16'h0800, 16'h0000);
    cores_save_done = 3'b111;
    repeat (3) step();
    chk("R8 fatal sticky", fatal, 1);
    chk("R8 busy", busy, 1);
    chk("R8 mem_req blocked", mem_req, 0);
    chk("R8 no core reset", core_rst_n, 1);

    finish_run();
  end
endmodule